// File: doc/BRIEF.md
# Edge-Latching Interrupt Controller

This block collects a set of external interrupt lines for a small processor core and turns them into one registered request. Each line is watched for a low-to-high transition. A transition sets a sticky bit in a status register. A mask register then decides which pending bits may reach the core, and a global enable decides whether any request reaches it at all. The two lowest lines are always allowed through, whatever their mask bits hold.

The block also holds the two low-power enable bits, doze and sleep. Any line transition forces both bits low so that the core wakes for the interrupt. A run-time bypass input puts the block into a pass-through mode. In bypass the mask and status registers are left alone, and a line transition produces a one-cycle request to the core, provided the global enable is set.

Software reaches the mask, status and power bits through a simple write port with a select field and a separate combinational read port.

Top module: `line_irq_ctrl`

## Requirements
- R1: A low-to-high transition of line i, seen while `ctrl_en` is 1, sets status bit i at the next clock edge. A line that stays high does not set its bit again after software has cleared it.
- R2: A write with `wr_sel`=1 replaces the status register with `wr_data`. A transition that happens in the same cycle as the write still sets its bit.
- R3: Lines 0 and 1 produce a request whether or not their mask bits are set. Every other line needs its mask bit (select 0) set to 1.
- R4: `irq_o` is 0 in any cycle that follows a cycle with `glob_ie` at 0. When `glob_ie` goes to 1 while enabled pending bits exist, `irq_o` rises at the next edge.
- R5: In enabled mode, `irq_o` is a registered level. It is 1 in the cycle after one in which `glob_ie` is 1 and (status AND (mask OR 0x3)) is nonzero, and it stays 1 as long as that condition holds.
- R6: Any line transition clears both doze (bit 0) and sleep (bit 1) of the power register (select 2) at the next edge. This takes priority over a power-register write in the same cycle.
- R7: With `ctrl_en` at 0, line transitions leave the status and mask registers unchanged. `irq_o` is then 1 for exactly the one cycle after a transition, provided `glob_ie` was 1.
- R8: After reset, the mask, status, doze, sleep and `irq_o` are all 0.
- R9: `rd_data` returns the mask for `rd_sel`=0 and the status for `rd_sel`=1. For `rd_sel`=2 it returns doze in bit 0 and sleep in bit 1, with all other bits 0. For `rd_sel`=3 it returns zero.
- R10: After a line falls and rises again, the new rising edge is detected as a fresh transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_en | input | 1 | 1 selects normal mode, 0 selects bypass mode |
| glob_ie | input | 1 | Global interrupt enable from the core |
| irq_lines | input | NUM_LINES | External interrupt lines |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 mask, 1 status, 2 power |
| wr_data | input | REG_W | Write data |
| rd_sel | input | 2 | Read select, using the same encoding as `wr_sel` |
| rd_data | output | REG_W | Read data |
| doze_en | output | 1 | Doze enable bit |
| sleep_en | output | 1 | Sleep enable bit |
| irq_o | output | 1 | Registered interrupt request to the core |

## Verification
The hardest cases to reach are the collisions. One is a software write to the status or power register landing in the same cycle as a line's rising edge. The other is a line that stays high across a status clear and must not re-latch. The stimulus creates both deliberately: it raises a new line in exactly the cycle that carries the clearing write, and it keeps an earlier line held high while the status is cleared. It also toggles a line low and high again to show that the edge is detected afresh. A cycle-accurate behavioural model checks every output on every clock throughout these sequences.

// File: rtl/lic_pkg.sv
package lic_pkg;
   typedef enum logic [1:0] {
      SEL_MASK = 2'd0,
      SEL_STAT = 2'd1,
      SEL_PWR  = 2'd2,
      SEL_NONE = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/lic_edge_det.sv
module lic_edge_det #(
   parameter int NUM_LINES = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] lines,
   output logic [NUM_LINES-1:0] evt
);
   logic [NUM_LINES-1:0] level_q;

   for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) level_q[i] <= 1'b0;
         else        level_q[i] <= lines[i];
      end
      assign evt[i] = lines[i] & ~level_q[i];
   end
endmodule

// File: rtl/lic_regs.sv
module lic_regs
   import lic_pkg::*;
#(
   parameter int NUM_LINES = 32,
   parameter int REG_W     = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 ctrl_en,
   input  logic [NUM_LINES-1:0] evt,
   input  logic                 wr_en,
   input  logic [1:0]           wr_sel,
   input  logic [REG_W-1:0]     wr_data,
   output logic [NUM_LINES-1:0] mask_q,
   output logic [NUM_LINES-1:0] stat_q
);
   logic stat_wr, mask_wr;
   logic [NUM_LINES-1:0] stat_base;

   assign stat_wr   = wr_en && (reg_sel_e'(wr_sel) == SEL_STAT);
   assign mask_wr   = wr_en && (reg_sel_e'(wr_sel) == SEL_MASK);
   assign stat_base = stat_wr ? wr_data[NUM_LINES-1:0] : stat_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
         stat_q <= '0;
      end else begin
         if (mask_wr) mask_q <= wr_data[NUM_LINES-1:0];
         stat_q <= ctrl_en ? (stat_base | evt) : stat_base;
      end
   end

   // R1
   edge_sets_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_en && (|evt)) |=> ((stat_q & $past(evt)) == $past(evt)));
   // R7
   bypass_keeps_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_en && !stat_wr) |=> $stable(stat_q));
endmodule

// File: rtl/lic_pwr.sv
module lic_pwr
   import lic_pkg::*;
#(
   parameter int REG_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             any_evt,
   input  logic             wr_en,
   input  logic [1:0]       wr_sel,
   input  logic [REG_W-1:0] wr_data,
   output logic             doze_en,
   output logic             sleep_en
);
   logic pwr_wr;
   assign pwr_wr = wr_en && (reg_sel_e'(wr_sel) == SEL_PWR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         doze_en  <= 1'b0;
         sleep_en <= 1'b0;
      end else if (any_evt) begin
         doze_en  <= 1'b0;
         sleep_en <= 1'b0;
      end else if (pwr_wr) begin
         doze_en  <= wr_data[0];
         sleep_en <= wr_data[1];
      end
   end

   // R6
   wake_clears_pwr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      any_evt |=> (!doze_en && !sleep_en));
endmodule

// File: rtl/lic_req.sv
module lic_req #(
   parameter int NUM_LINES  = 32,
   parameter int N_UNMASK   = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 ctrl_en,
   input  logic                 glob_ie,
   input  logic [NUM_LINES-1:0] evt,
   input  logic [NUM_LINES-1:0] mask_q,
   input  logic [NUM_LINES-1:0] stat_q,
   output logic                 irq_o
);
   logic [NUM_LINES-1:0] fixed_en, pass;
   logic req_next;

   for (genvar i = 0; i < NUM_LINES; i++) begin : g_fixed
      if (i < N_UNMASK) begin : g_on
         assign fixed_en[i] = 1'b1;
      end else begin : g_off
         assign fixed_en[i] = 1'b0;
      end
   end

   assign pass     = stat_q & (mask_q | fixed_en);
   assign req_next = glob_ie && (ctrl_en ? (|pass) : (|evt));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_o <= 1'b0;
      else        irq_o <= req_next;
   end

   // R4
   ie_gates_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !glob_ie |=> !irq_o);
   // R3
   unmaskable_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_en && glob_ie && (|(stat_q & fixed_en))) |=> irq_o);
endmodule

// File: rtl/line_irq_ctrl.sv
module line_irq_ctrl
   import lic_pkg::*;
#(
   parameter int NUM_LINES = 32,
   parameter int REG_W     = 32,
   parameter int N_UNMASK  = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 ctrl_en,
   input  logic                 glob_ie,
   input  logic [NUM_LINES-1:0] irq_lines,
   input  logic                 wr_en,
   input  logic [1:0]           wr_sel,
   input  logic [REG_W-1:0]     wr_data,
   input  logic [1:0]           rd_sel,
   output logic [REG_W-1:0]     rd_data,
   output logic                 doze_en,
   output logic                 sleep_en,
   output logic                 irq_o
);
   if (NUM_LINES > REG_W) begin : g_bad_w
      $error("NUM_LINES must not exceed REG_W");
   end
   if (N_UNMASK > NUM_LINES) begin : g_bad_u
      $error("N_UNMASK must not exceed NUM_LINES");
   end
   if (REG_W < 2) begin : g_bad_r
      $error("REG_W must hold the two power bits");
   end

   logic [NUM_LINES-1:0] evt, mask_q, stat_q;

   lic_edge_det #(.NUM_LINES(NUM_LINES)) u_edge (
      .clk(clk), .rst_n(rst_n), .lines(irq_lines), .evt(evt));

   lic_regs #(.NUM_LINES(NUM_LINES), .REG_W(REG_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .ctrl_en(ctrl_en), .evt(evt),
      .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .mask_q(mask_q), .stat_q(stat_q));

   lic_pwr #(.REG_W(REG_W)) u_pwr (
      .clk(clk), .rst_n(rst_n), .any_evt(|evt),
      .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .doze_en(doze_en), .sleep_en(sleep_en));

   lic_req #(.NUM_LINES(NUM_LINES), .N_UNMASK(N_UNMASK)) u_req (
      .clk(clk), .rst_n(rst_n), .ctrl_en(ctrl_en), .glob_ie(glob_ie),
      .evt(evt), .mask_q(mask_q), .stat_q(stat_q), .irq_o(irq_o));

   always_comb begin
      unique case (reg_sel_e'(rd_sel))
         SEL_MASK: rd_data = REG_W'(mask_q);
         SEL_STAT: rd_data = REG_W'(stat_q);
         SEL_PWR:  rd_data = REG_W'({sleep_en, doze_en});
         default:  rd_data = '0;
      endcase
   end
endmodule

// File: tb/line_irq_ctrl_test.sv
`timescale 1ns/100ps
module line_irq_ctrl_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ctrl_en = 1'b1, glob_ie = 1'b0, wr_en = 1'b0;
   logic [31:0] irq_lines = '0, wr_data = '0, rd_data;
   logic [1:0]  wr_sel = 2'd0, rd_sel = 2'd0;
   logic        doze_en, sleep_en, irq_o;

   int errors = 0;
   int checks = 0;

   bit [31:0] m_mask, m_stat, m_lvl;
   bit        m_irq, m_doze, m_sleep;

   always #2.5 clk = ~clk;

   line_irq_ctrl uut (
      .clk(clk), .rst_n(rst_n), .ctrl_en(ctrl_en), .glob_ie(glob_ie),
      .irq_lines(irq_lines), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
      .doze_en(doze_en), .sleep_en(sleep_en), .irq_o(irq_o));

   // behavioural reference, updated at every rising edge
   always @(posedge clk) begin : model
      bit [31:0] ev, ns;
      bit        any, nirq;
      if (!rst_n) begin
         m_mask = 0; m_stat = 0; m_lvl = 0;
         m_irq = 0; m_doze = 0; m_sleep = 0;
      end else begin
         ev   = irq_lines & ~m_lvl;
         any  = (ev != 0);
         nirq = ctrl_en ? (glob_ie && ((m_stat & (m_mask | 32'h3)) != 0))
                        : (glob_ie && any);
         ns = m_stat;
         if (wr_en && wr_sel == 2'd1) ns = wr_data;
         if (ctrl_en) ns = ns | ev;
         if (wr_en && wr_sel == 2'd0) m_mask = wr_data;
         if (any) begin
            m_doze = 0; m_sleep = 0;
         end else if (wr_en && wr_sel == 2'd2) begin
            m_doze = wr_data[0]; m_sleep = wr_data[1];
         end
         m_stat = ns;
         m_irq  = nirq;
         m_lvl  = irq_lines;
      end
   end

   task automatic expect_v(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic bit [31:0] model_rd(input logic [1:0] s);
      case (s)
         2'd0: return m_mask;
         2'd1: return m_stat;
         2'd2: return {30'd0, m_sleep, m_doze};
         default: return 32'd0;
      endcase
   endfunction

   task automatic tick();
      @(negedge clk);
      expect_v(ctrl_en ? "R5 irq model" : "R7 irq model", 32'(irq_o), 32'(m_irq));
      expect_v("R9 read model", rd_data, model_rd(rd_sel));
      expect_v("R6 doze model", 32'(doze_en), 32'(m_doze));
      expect_v("R6 sleep model", 32'(sleep_en), 32'(m_sleep));
   endtask

   task automatic write_reg(input logic [1:0] s, input logic [31:0] d);
      wr_en = 1'b1; wr_sel = s; wr_data = d;
      tick();
      wr_en = 1'b0;
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : stim
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      tick();
      // R8 reset state
      expect_v("R8 mask", rd_data, 32'd0);
      expect_v("R8 irq", 32'(irq_o), 32'd0);
      expect_v("R8 pwr", 32'({sleep_en, doze_en}), 32'd0);

      write_reg(2'd0, 32'h10);
      rd_sel = 2'd1;
      irq_lines[4] = 1'b1;
      tick();
      expect_v("R1 edge sets bit4", rd_data, 32'h10);
      tick();
      expect_v("R4 blocked by ie", 32'(irq_o), 32'd0);
      glob_ie = 1'b1;
      tick();
      expect_v("R4 ie raise", 32'(irq_o), 32'd1);

      write_reg(2'd1, 32'd0);
      expect_v("R2 status cleared", rd_data, 32'd0);
      tick();
      expect_v("R1 held line not relatched", rd_data, 32'd0);
      expect_v("R5 irq drops", 32'(irq_o), 32'd0);

      irq_lines[4] = 1'b0; tick();
      irq_lines[4] = 1'b1; tick();
      expect_v("R10 re-detect", rd_data, 32'h10);
      tick();
      expect_v("R5 irq level", 32'(irq_o), 32'd1);
      tick();
      expect_v("R5 irq held", 32'(irq_o), 32'd1);

      write_reg(2'd1, 32'd0); tick();
      irq_lines[7] = 1'b1; tick();
      expect_v("R3 masked bit7 latched", rd_data, 32'h80);
      tick(); tick();
      expect_v("R3 masked no irq", 32'(irq_o), 32'd0);
      irq_lines[1] = 1'b1; tick();
      expect_v("R3 bit1 latched", rd_data, 32'h82);
      tick();
      expect_v("R3 unmaskable irq", 32'(irq_o), 32'd1);

      write_reg(2'd1, 32'd0); tick();
      rd_sel = 2'd2;
      write_reg(2'd2, 32'd3);
      expect_v("R9 pwr read", rd_data, 32'd3);
      irq_lines[9] = 1'b1; tick();
      expect_v("R6 wake clears", 32'({sleep_en, doze_en}), 32'd0);
      wr_en = 1'b1; wr_sel = 2'd2; wr_data = 32'd3; irq_lines[10] = 1'b1;
      tick();
      wr_en = 1'b0;
      expect_v("R6 wake beats write", 32'({sleep_en, doze_en}), 32'd0);

      rd_sel = 2'd1;
      wr_en = 1'b1; wr_sel = 2'd1; wr_data = 32'd0; irq_lines[12] = 1'b1;
      tick();
      wr_en = 1'b0;
      expect_v("R2 event beats clear", rd_data, 32'h1000);

      write_reg(2'd1, 32'd0); tick();
      ctrl_en = 1'b0;
      irq_lines[20] = 1'b1; tick();
      expect_v("R7 bypass irq", 32'(irq_o), 32'd1);
      expect_v("R7 status untouched", rd_data, 32'd0);
      tick();
      expect_v("R7 bypass pulse ends", 32'(irq_o), 32'd0);
      rd_sel = 2'd0; tick();
      expect_v("R7 mask untouched", rd_data, 32'h10);
      rd_sel = 2'd3; tick();
      expect_v("R9 unused select", rd_data, 32'd0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule